// File: doc/BRIEF.md
# Distributed Partition Address Sequencer

This block produces the address and enable for each RAM port that holds one slice of a packed multi-line pixel buffer. The buffer is built from segments, and each segment is made of one or more partitions, each mapped to a window of a RAM port. The block does not keep one line pointer and decode it. Each partition owns a local counter, and that counter is the port address. A single enable token moves from partition to partition inside each segment. On every valid pixel, the partition that holds the token steps its address. When it reaches the end of its window, it reloads its start address and passes the token on.

The start address, the depth of every partition and the segment boundaries are parameters. Token order follows the partition index. After the last partition of a segment, the token returns to the first. A segment with one partition keeps its enable high and only wraps its address. The default setup has two segments. The first segment is a 512-deep window from address 0, followed by a 128-deep window from address 320. The second segment is a single 640-deep window from address 0. RAM storage, data steering and the image operator sit outside this block.

Top module: `part_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every partition that opens a segment raises its enable bit, every other partition clears its enable bit, and each address output loads its partition's start address. `pix_valid_i` is ignored during reset.
- R2: From reset onward, exactly one enable bit is high within each segment in every cycle.
- R3: Each partition's address always lies between its start address and its start address plus depth minus one.
- R4: On a clock edge with `pix_valid_i` high, an enabled partition that is not at its last location increments its address by one and keeps its enable.
- R5: On a clock edge with `pix_valid_i` high, an enabled partition at its last location reloads its start address and drops its enable. On the same edge, the partition with the next higher index in the segment raises its enable.
- R6: When the partition that wraps is the last one of its segment, the token moves to the segment's first partition.
- R7: A single-partition segment keeps its enable high. It wraps its address from start plus depth minus one back to its start address.
- R8: A partition without the token holds its start address.
- R9: On a clock edge with `pix_valid_i` low, every enable and address output holds its value.
- R10: Enable and address outputs come from registers. The result of a valid pixel appears on the outputs right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid_i | input | 1 | High when a pixel is accepted this cycle |
| port_en_o | output | NUM_PART | Registered enable per partition, bit p for partition p |
| port_addr_o | output | NUM_PART*ADDR_W | Registered address per partition, partition p in bits [p*ADDR_W +: ADDR_W] |

## Verification
Every result is due one clock edge after the valid pixel that causes it. That holds for an increment, a wrap with its token move, and the reload under reset. The bench drives `pix_valid_i` just after a rising edge. It compares all outputs just after the next rising edge, once the registers have taken that pixel. A per-segment line counter, decoded into expected enables and addresses, is advanced at that same point. The two sides therefore stay one edge in step over thousands of cycles and several line wraps.

// File: rtl/part_addr_seq_pkg.sv
// Package: constant helpers that derive segment structure from a mask
// that flags the first partition of each segment. Assumes bit 0 is set
// and at most 32 partitions.
package part_addr_seq_pkg;

    localparam int MAX_PART = 32;

    // Index of the last partition in the segment that holds partition p.
    function automatic int seg_last(input logic [MAX_PART-1:0] first, input int n, input int p);
        int  last;
        bit  done;
        last = p;
        done = 1'b0;
        for (int i = p + 1; i < n; i++) begin
            if (first[i]) done = 1'b1;
            if (!done) last = i;
        end
        return last;
    endfunction

    // Index of the first partition in the segment that holds partition p.
    function automatic int seg_first(input logic [MAX_PART-1:0] first, input int p);
        int  head;
        bit  done;
        head = 0;
        done = 1'b0;
        for (int i = p; i >= 0; i--) begin
            if (!done && first[i]) begin
                head = i;
                done = 1'b1;
            end
        end
        return head;
    endfunction

    // Partition that hands the token to partition p.
    function automatic int tok_pred(input logic [MAX_PART-1:0] first, input int n, input int p);
        return first[p] ? seg_last(first, n, p) : p - 1;
    endfunction

    // Partition that receives the token from partition p.
    function automatic int tok_succ(input logic [MAX_PART-1:0] first, input int n, input int p);
        return (seg_last(first, n, p) == p) ? seg_first(first, p) : p + 1;
    endfunction

    // Number of segments.
    function automatic int seg_count(input logic [MAX_PART-1:0] first, input int n);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) if (first[i]) c++;
        return c;
    endfunction

    // Mask of partitions that belong to segment s.
    function automatic logic [MAX_PART-1:0] seg_mask(input logic [MAX_PART-1:0] first, input int n, input int s);
        logic [MAX_PART-1:0] m;
        int                  idx;
        m   = '0;
        idx = -1;
        for (int i = 0; i < n; i++) begin
            if (first[i]) idx++;
            if (idx == s) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/part_addr_cell.sv
// Partition cell: owns the enable token flag and the local address
// counter of one partition. The counter is the RAM port address itself.
// Assumes DEPTH >= 1 and START+DEPTH fits in ADDR_W bits. A self-looped
// segment is handled by feeding the cell's own wrap back as take_i.
module part_addr_cell #(
    parameter int ADDR_W   = 10,
    parameter int START    = 0,
    parameter int DEPTH    = 512,
    parameter bit IS_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    input  logic              take_i,
    output logic              wrap_o,
    output logic              en_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(START);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(START + DEPTH - 1);

    logic              en_q;
    logic [ADDR_W-1:0] addr_q;
    logic              at_last;
    logic              step;

    // Decode: this partition consumes a pixel, and whether it is the last slot.
    always_comb begin
        at_last = (addr_q == A_LAST);
        step    = en_q & pix_valid_i;
        wrap_o  = step & at_last;
    end

    // Token flag: drop on own wrap, pick up when the predecessor wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= IS_FIRST;
        else        en_q <= (en_q & ~wrap_o) | take_i;
    end

    // Local pointer: count while holding the token, reload at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= A_START;
        else if (step)   addr_q <= at_last ? A_START : addr_q + 1'b1;
    end

    assign en_o   = en_q;
    assign addr_o = addr_q;

    // R3: address confined to the partition window
    a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q >= A_START) && (addr_q <= A_LAST));

    // R4: step by one inside the window
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && pix_valid_i && !at_last) |=> (en_q && addr_q == $past(addr_q) + 1'b1));

    // R5: reload the start address after the last slot
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (addr_q == A_START));

    // R8: an idle partition parks at its start address
    a_r8_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (addr_q == A_START));

    // R9: nothing moves without a valid pixel
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> ($stable(addr_q) && $stable(en_q)));
endmodule

// File: rtl/part_token_link.sv
// Token link: routes each partition's wrap pulse to its successor's take
// input, following partition index inside each segment and closing the
// ring from the last partition back to the first. Purely combinational.
module part_token_link
    import part_addr_seq_pkg::*;
#(
    parameter int                  NUM_PART   = 3,
    parameter logic [NUM_PART-1:0] PART_FIRST = 3'b101
) (
    input  logic [NUM_PART-1:0] wrap_i,
    output logic [NUM_PART-1:0] take_o
);
    localparam logic [MAX_PART-1:0] FIRST_W = MAX_PART'(PART_FIRST);

    for (genvar p = 0; p < NUM_PART; p++) begin : g_link
        localparam int PRED = tok_pred(FIRST_W, NUM_PART, p);
        // Take the token when the predecessor leaves its last slot.
        assign take_o[p] = wrap_i[PRED];
    end
endmodule

// File: rtl/part_addr_seq.sv
// Top: distributed address sequencer for a packed multi-line buffer.
// One cell per partition; token links close each segment into a ring.
// Assumes PART_FIRST[0] = 1 and that partitions of a segment are contiguous.
module part_addr_seq
    import part_addr_seq_pkg::*;
#(
    parameter int                  NUM_PART              = 3,
    parameter int                  ADDR_W                = 10,
    parameter logic [NUM_PART-1:0] PART_FIRST            = 3'b101,
    parameter int                  PART_START [NUM_PART] = '{0, 320, 0},
    parameter int                  PART_DEPTH [NUM_PART] = '{512, 128, 640}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pix_valid_i,
    output logic [NUM_PART-1:0]          port_en_o,
    output logic [NUM_PART*ADDR_W-1:0]   port_addr_o
);
    localparam logic [MAX_PART-1:0] FIRST_W = MAX_PART'(PART_FIRST);
    localparam int                  NUM_SEG = seg_count(FIRST_W, NUM_PART);

    logic [NUM_PART-1:0] wrap;
    logic [NUM_PART-1:0] take;

    // Ring wiring between partitions of the same segment.
    part_token_link #(
        .NUM_PART   (NUM_PART),
        .PART_FIRST (PART_FIRST)
    ) u_link (
        .wrap_i (wrap),
        .take_o (take)
    );

    for (genvar p = 0; p < NUM_PART; p++) begin : g_part
        part_addr_cell #(
            .ADDR_W   (ADDR_W),
            .START    (PART_START[p]),
            .DEPTH    (PART_DEPTH[p]),
            .IS_FIRST (PART_FIRST[p])
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .pix_valid_i (pix_valid_i),
            .take_i      (take[p]),
            .wrap_o      (wrap[p]),
            .en_o        (port_en_o[p]),
            .addr_o      (port_addr_o[p*ADDR_W +: ADDR_W])
        );

        localparam int SUCC = tok_succ(FIRST_W, NUM_PART, p);
        if (SUCC == p) begin : g_solo
            // R7: a lone partition never loses its enable
            a_r7_solo_always_on: assert property (@(posedge clk) disable iff (!rst_n)
                port_en_o[p]);
        end else if (SUCC > p) begin : g_fwd
            // R5: token moves to the next partition on the wrap
            a_r5_pass_next: assert property (@(posedge clk) disable iff (!rst_n)
                wrap[p] |=> (port_en_o[SUCC] && !port_en_o[p]));
        end else begin : g_back
            // R6: the last partition returns the token to the first
            a_r6_back_to_first: assert property (@(posedge clk) disable iff (!rst_n)
                wrap[p] |=> (port_en_o[SUCC] && !port_en_o[p]));
        end
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam logic [NUM_PART-1:0] MASK = NUM_PART'(seg_mask(FIRST_W, NUM_PART, s));
        // R2: exactly one live token per segment
        a_r2_one_token: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(port_en_o & MASK) == 1);
    end
endmodule

// File: tb/sim_part_addr_seq.sv
// Bench for part_addr_seq in its default configuration: two segments,
// the first split 512 @ 0 + 128 @ 320, the second one 640-deep window @ 0.
module sim_part_addr_seq;
    localparam int AW = 10;
    localparam int NP = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pix_valid_i = 1'b0;
    logic [NP-1:0]   port_en_o;
    logic [NP*AW-1:0] port_addr_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    int ptr0 = 0;
    int ptr1 = 0;

    always #5 clk = ~clk;

    part_addr_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid_i),
        .port_en_o   (port_en_o),
        .port_addr_o (port_addr_o)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired: actual cycles=%0d expected <=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Table: valid pulses to apply, then expected a0, a1, a2, enables.
    localparam int VEC [7][5] = '{
        '{0,   0,   320, 0,   5},
        '{5,   5,   320, 5,   5},
        '{506, 511, 320, 511, 5},
        '{1,   0,   320, 512, 6},
        '{127, 0,   447, 639, 6},
        '{1,   0,   320, 0,   5},
        '{700, 60,  320, 60,  5}
    };

    function automatic logic [AW-1:0] addr_of(input int p);
        return port_addr_o[p*AW +: AW];
    endfunction

    task automatic compare(input logic [NP-1:0] e_en, input int e0, input int e1, input int e2,
                           input string req);
        checks++;
        if (port_en_o !== e_en || addr_of(0) !== AW'(e0) || addr_of(1) !== AW'(e1)
            || addr_of(2) !== AW'(e2)) begin
            failures++;
            $display("FAIL %s: actual en=%b a=%0d/%0d/%0d expected en=%b a=%0d/%0d/%0d",
                     req, port_en_o, addr_of(0), addr_of(1), addr_of(2), e_en, e0, e1, e2);
        end
    endtask

    // Line-pointer reference, decoded into per-partition expectations.
    task automatic compare_model(input string req);
        logic [NP-1:0] e_en;
        e_en = {1'b1, ptr0 >= 512, ptr0 < 512};
        compare(e_en, (ptr0 < 512) ? ptr0 : 0, (ptr0 >= 512) ? 320 + ptr0 - 512 : 320, ptr1, req);
    endtask

    // One clock: drive valid, let the edge sample it, then update the model.
    task automatic tick(input logic v);
        pix_valid_i = v;
        @(posedge clk);
        #1;
        if (v && rst_n) begin
            ptr0 = (ptr0 + 1) % 640;
            ptr1 = (ptr1 + 1) % 640;
        end
    endtask

    task automatic do_reset(input logic v);
        rst_n = 1'b0;
        tick(v);
        tick(v);
        rst_n = 1'b1;
        ptr0 = 0;
        ptr1 = 0;
    endtask

    initial begin
        logic [15:0] lfsr;
        do_reset(1'b1);
        // R1: reset state even with valid held high
        compare(3'b101, 0, 320, 0, "R1 reset");

        // Vector walk: R4 stepping, R5 hand-over, R6 return, R7 solo wrap, R10 one-edge latency
        foreach (VEC[i]) begin
            for (int k = 0; k < VEC[i][0]; k++) tick(1'b1);
            compare(NP'(VEC[i][4]), VEC[i][1], VEC[i][2], VEC[i][3], "R4/R5/R6/R7/R10 table");
        end

        // R9: idle cycles leave everything untouched (model at 60)
        for (int k = 0; k < 6; k++) tick(1'b0);
        compare(3'b101, 60, 320, 60, "R9 hold");

        // R8: move into partition 1, then partition 0 must sit at its start
        for (int k = 0; k < 460; k++) tick(1'b1);
        compare(3'b110, 0, 328, 520, "R8 parked");
        tick(1'b0);
        compare(3'b110, 0, 328, 520, "R9 hold in partition 1");

        // R1: reset in mid-line restores the start state
        do_reset(1'b0);
        compare(3'b101, 0, 320, 0, "R1 mid-run reset");

        // R2..R7: irregular valid pattern against the line-pointer reference
        lfsr = 16'hACE1;
        for (int k = 0; k < 6000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(lfsr[0] | lfsr[3]);
            compare_model("R2/R3/R5/R6/R7 reference");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule